// File: doc/BRIEF.md
# Multicycle 16-bit Subset Processor

This block is a small multicycle processor for a 16-bit, word-addressed instruction set. It holds eight general registers, a program counter, a memory address register, a memory data register, an instruction register and three condition flags (negative, zero, positive). It runs four instructions: add with a signed immediate, a store relative to the program counter, a conditional branch, and a load of a computed address into a register. All offsets are added to the program counter after fetch has incremented it, not to the instruction's own address.

The core drives one synchronous single-port word memory. A read returns data one clock after the address is presented. Each instruction passes through fetch, decode and execute states. A store adds one more state for its memory write. A one-cycle completion pulse marks the end of each instruction, so a testbench can sample the program counter, address register, instruction register and register file at that point. If the core meets an encoding outside the subset, it stops and raises a halt flag.

Top module: `mc16_core`

## Requirements
- R1: While reset is high and in the cycle after it falls, the PC holds the RESET_PC parameter (default x1800), all eight registers and the condition flags read zero, halted is low, and no memory write is issued.
- R2: Fetch makes exactly one memory read, at the PC. The MAR takes the fetch address, the IR takes the word read, and the PC becomes the fetch address plus one.
- R3: Opcode 0001 with bit 5 set is an immediate add. Bits 11:9 name the destination, bits 8:6 the source, and bits 4:0 a signed immediate. The destination receives source plus the sign-extended immediate.
- R4: The flag output is ordered {N,Z,P}. An add sets exactly one flag: 100 for a result with bit 15 set, 010 for zero, 001 otherwise. No other instruction changes the flags.
- R5: Opcode 0011 is a store. Bits 11:9 name the source register and bits 8:0 a signed offset. It makes one memory write of that register to (PC after fetch) + offset, leaves that target in the MAR, and writes no register.
- R6: Opcode 0000 is a branch. Bits 11:9 form a mask {n,z,p} and bits 8:0 a signed offset. The branch is taken when the mask is 111, or when the mask ANDed with the flags is nonzero. When taken, the PC becomes (PC after fetch) + offset. The MAR and the registers are unchanged.
- R7: Opcode 1110 loads an address. Bits 11:9 name the destination, which receives (PC after fetch) + the sign-extended 9-bit offset. No memory access follows fetch.
- R8: The done output pulses high for one cycle per finished instruction. Add, branch and address load take 3 cycles from one pulse to the next; a store takes 4.
- R9: Any opcode outside the four, and opcode 0001 with bit 5 clear, sets halted. After that, done never pulses, no write is issued, and the PC stays fixed until reset.
- R10: Only a branch changes the PC after fetch. After an add, a store or an address load, the PC equals the fetch address plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| done | output | 1 | One-cycle pulse at instruction completion |
| halted | output | 1 | High once an unsupported encoding has been executed |
| pc_out | output | 16 | Program counter |
| mar_out | output | 16 | Memory address register |
| ir_out | output | 16 | Instruction register |
| cc_out | output | 3 | Condition flags {N,Z,P} |
| regs_out | output | 128 | Register file, register k at bits 16k+15:16k |

## Verification
A chain of adds covers a negative result from a zero source, a zero result, a positive result from a negative source, and a wrap into the negative range. This checks sign extension and each of the three flag encodings. A program of an address load, a store and a backward branch rewrites its own first word and then jumps back to run it. This separates the store target (incremented PC) from the fetch address. It also shows that a mask of 111 is taken with the flags all clear, and that the MAR keeps its value across a branch. A branch sequence with the zero flag set tries a mask that misses, a forward mask that hits, and a mask of 000. Two illegal words, an unknown opcode and an add with its mode bit clear, confirm that the core stops for good.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);

    localparam logic [3:0] OP_BR  = 4'h0;
    localparam logic [3:0] OP_ADD = 4'h1;
    localparam logic [3:0] OP_ST  = 4'h3;
    localparam logic [3:0] OP_LEA = 4'hE;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_STORE,
        S_HALT
    } state_e;

    typedef struct packed {
        logic [3:0]      op;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] off;
        logic [2:0]      mask;
        logic            legal;
    } dec_t;

    function automatic logic [XLEN-1:0] sext5(input logic [4:0] v);
        return {{(XLEN-5){v[4]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext9(input logic [8:0] v);
        return {{(XLEN-9){v[8]}}, v};
    endfunction

    // flag order {N,Z,P}
    function automatic logic [2:0] nzp_of(input logic [XLEN-1:0] v);
        if (v[XLEN-1])   return 3'b100;
        else if (v == '0) return 3'b010;
        else              return 3'b001;
    endfunction

    function automatic dec_t decode(input logic [XLEN-1:0] w);
        dec_t d;
        d.op    = w[15:12];
        d.rd    = w[11:9];
        // a store reads its data register from the destination slot
        d.rs    = (w[15:12] == OP_ST) ? w[11:9] : w[8:6];
        d.imm   = sext5(w[4:0]);
        d.off   = sext9(w[8:0]);
        d.mask  = w[11:9];
        d.legal = ((w[15:12] == OP_ADD) && w[5]) ||
                  (w[15:12] == OP_ST) || (w[15:12] == OP_BR) ||
                  (w[15:12] == OP_LEA);
        return d;
    endfunction
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile
    import mc16_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AW-1:0]  raddr,
    output logic [W-1:0]   rdata,
    output logic [N*W-1:0] flat
);
    logic [W-1:0] r_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) r_q[i] <= '0;
        end else if (we) begin
            r_q[waddr] <= wdata;
        end
    end

    assign rdata = r_q[raddr];

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign flat[g*W +: W] = r_q[g];
    end
endmodule

// File: rtl/mc16_exec.sv
module mc16_exec
    import mc16_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] off,
    input  logic [2:0]      mask,
    input  logic [2:0]      cc,
    output logic [XLEN-1:0] add_res,
    output logic [2:0]      add_cc,
    output logic [XLEN-1:0] ea,
    output logic            taken
);
    always_comb begin
        add_res = src + imm;
        add_cc  = nzp_of(add_res);
        ea      = pc + off;
        taken   = (&mask) | (|(mask & cc));
    end
endmodule

// File: rtl/mc16_seq.sv
module mc16_seq
    import mc16_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   legal,
    input  logic   is_store,
    output state_e state,
    output logic   done
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: nxt = S_EXEC;
            S_EXEC:   nxt = !legal ? S_HALT : (is_store ? S_STORE : S_FETCH);
            S_STORE:  nxt = S_FETCH;
            default:  nxt = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= ((state == S_EXEC) && legal && !is_store) || (state == S_STORE);
        end
    end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h1800
) (
    input  logic         clk,
    input  logic         rst,
    output logic [15:0]  mem_addr,
    output logic [15:0]  mem_wdata,
    output logic         mem_we,
    input  logic [15:0]  mem_rdata,
    output logic         done,
    output logic         halted,
    output logic [15:0]  pc_out,
    output logic [15:0]  mar_out,
    output logic [15:0]  ir_out,
    output logic [2:0]   cc_out,
    output logic [127:0] regs_out
);
    logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q;
    logic [2:0]      cc_q;
    state_e          state;
    dec_t            dec;
    logic [XLEN-1:0] src, add_res, ea;
    logic [2:0]      add_cc;
    logic            taken, rf_we;

    assign dec = decode(ir_q);

    mc16_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .legal    (dec.legal),
        .is_store (dec.op == OP_ST),
        .state    (state),
        .done     (done)
    );

    assign rf_we = (state == S_EXEC) && dec.legal &&
                   ((dec.op == OP_ADD) || (dec.op == OP_LEA));

    mc16_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (dec.rd),
        .wdata ((dec.op == OP_ADD) ? add_res : ea),
        .raddr (dec.rs),
        .rdata (src),
        .flat  (regs_out)
    );

    mc16_exec u_exec (
        .pc      (pc_q),
        .src     (src),
        .imm     (dec.imm),
        .off     (dec.off),
        .mask    (dec.mask),
        .cc      (cc_q),
        .add_res (add_res),
        .add_cc  (add_cc),
        .ea      (ea),
        .taken   (taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            cc_q  <= '0;
        end else begin
            case (state)
                S_FETCH: begin
                    mar_q <= pc_q;
                    pc_q  <= pc_q + 1'b1;
                end
                S_DECODE: ir_q <= mem_rdata;
                S_EXEC: begin
                    if (dec.legal) begin
                        case (dec.op)
                            OP_ADD: cc_q <= add_cc;
                            OP_ST: begin
                                mar_q <= ea;
                                mdr_q <= src;
                            end
                            OP_BR: if (taken) pc_q <= ea;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = (state == S_FETCH) ? pc_q : mar_q;
    assign mem_wdata = mdr_q;
    assign mem_we    = (state == S_STORE);
    assign halted    = (state == S_HALT);
    assign pc_out    = pc_q;
    assign mar_out   = mar_q;
    assign ir_out    = ir_q;
    assign cc_out    = cc_q;
endmodule

// File: rtl/mc16_chk.sv
module mc16_chk
    import mc16_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] pc_out,
    input logic [15:0] mar_out,
    input logic [15:0] ir_out,
    input logic [2:0]  cc_out,
    input logic        done,
    input logic        halted
);
    // R5
    st_target_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr == pc_out + sext9(ir_out[8:0]));

    // R8
    st_finish_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cc_out));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc_out));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !done && !mem_we);

    // R10
    pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (ir_out[15:12] == OP_ADD || ir_out[15:12] == OP_LEA))
            |-> pc_out == mar_out + 16'd1);
endmodule

bind mc16_core mc16_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .pc_out   (pc_out),
    .mar_out  (mar_out),
    .ir_out   (ir_out),
    .cc_out   (cc_out),
    .done     (done),
    .halted   (halted)
);

// File: tb/sim_mc16_core.sv
module sim_mc16_core;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  mem_addr, mem_wdata, mem_rdata;
    logic         mem_we, done, halted;
    logic [15:0]  pc_out, mar_out, ir_out;
    logic [2:0]   cc_out;
    logic [127:0] regs_out;

    logic         ld_en = 1'b0;
    logic [7:0]   ld_addr = '0;
    logic [15:0]  ld_data = '0;
    logic [15:0]  mem [256];

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    mc16_core #(.RESET_PC(16'h1800)) u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done), .halted(halted),
        .pc_out(pc_out), .mar_out(mar_out), .ir_out(ir_out), .cc_out(cc_out),
        .regs_out(regs_out)
    );

    function automatic logic [15:0] rg(input int k);
        return regs_out[k*16 +: 16];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a[7:0]; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic go;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic hold_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_done(output int cyc, output int wr);
        cyc = 0; wr = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cyc++;
            if (mem_we) wr++;
            if (done) return;
        end
        cyc = -1;
    endtask

    task automatic t_reset;
        hold_reset();
        chk("R1 pc", pc_out, 16'h1800);
        for (int k = 0; k < 8; k++) chk("R1 reg", rg(k), 16'h0000);
        chk("R1 cc", {13'd0, cc_out}, 16'h0000);
        chk("R1 halted/we/done", {13'd0, halted, mem_we, done}, 16'h0000);
        go();
        chk("R1 pc after release", pc_out, 16'h1800);
    endtask

    task automatic t_add;
        int c, w;
        hold_reset();
        load(16'h1800, 16'h123F);
        load(16'h1801, 16'h1420);
        load(16'h1802, 16'h166F);
        load(16'h1803, 16'h1270);
        go();
        wait_done(c, w);
        chk("R8 add cycles", 16'(c), 16'd3);
        chk("R2 ir", ir_out, 16'h123F);
        chk("R2 mar", mar_out, 16'h1800);
        chk("R10 pc add", pc_out, 16'h1801);
        chk("R3 r1=-1", rg(1), 16'hFFFF);
        chk("R4 cc N", {13'd0, cc_out}, 16'h0004);
        chk("R7 no write add", 16'(w), 16'd0);
        wait_done(c, w);
        chk("R3 r2=0", rg(2), 16'h0000);
        chk("R4 cc Z", {13'd0, cc_out}, 16'h0002);
        wait_done(c, w);
        chk("R3 r3=14", rg(3), 16'h000E);
        chk("R4 cc P", {13'd0, cc_out}, 16'h0001);
        wait_done(c, w);
        chk("R3 r1 wrap", rg(1), 16'hFFEF);
        chk("R4 cc N again", {13'd0, cc_out}, 16'h0004);
        chk("R2 pc after four", pc_out, 16'h1804);
    endtask

    task automatic t_selfmod;
        int c, w;
        hold_reset();
        load(16'h1800, 16'hEA66);
        load(16'h1801, 16'h3BFE);
        load(16'h1802, 16'h0FFD);
        go();
        wait_done(c, w);
        chk("R7 lea value", rg(5), 16'h1867);
        chk("R7 lea no access", 16'(w), 16'd0);
        chk("R4 lea keeps cc", {13'd0, cc_out}, 16'h0000);
        chk("R10 pc lea", pc_out, 16'h1801);
        wait_done(c, w);
        chk("R8 store cycles", 16'(c), 16'd4);
        chk("R5 one write", 16'(w), 16'd1);
        chk("R5 stored word", mem[8'h00], 16'h1867);
        chk("R5 mar target", mar_out, 16'h1800);
        chk("R10 pc store", pc_out, 16'h1802);
        chk("R5 reg kept", rg(5), 16'h1867);
        wait_done(c, w);
        chk("R8 branch cycles", 16'(c), 16'd3);
        chk("R6 always taken", pc_out, 16'h1800);
        chk("R6 mar kept", mar_out, 16'h1802);
        wait_done(c, w);
        chk("R2 fetched rewritten", ir_out, 16'h1867);
        chk("R3 r4=r1+7", rg(4), 16'h0007);
        chk("R4 cc P", {13'd0, cc_out}, 16'h0001);
    endtask

    task automatic t_branch;
        int c, w;
        hold_reset();
        load(16'h1800, 16'h1020);
        load(16'h1801, 16'h0805);
        load(16'h1802, 16'h0402);
        load(16'h1805, 16'h0000);
        go();
        wait_done(c, w);
        chk("R4 zero flag", {13'd0, cc_out}, 16'h0002);
        wait_done(c, w);
        chk("R6 n miss", pc_out, 16'h1802);
        chk("R6 miss mar", mar_out, 16'h1801);
        wait_done(c, w);
        chk("R6 z hit forward", pc_out, 16'h1805);
        wait_done(c, w);
        chk("R6 mask 000", pc_out, 16'h1806);
        chk("R6 cc kept", {13'd0, cc_out}, 16'h0002);
    endtask

    task automatic t_halt(input logic [15:0] word);
        int dn, wr;
        dn = 0; wr = 0;
        hold_reset();
        load(16'h1800, word);
        go();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) dn++;
            if (mem_we) wr++;
        end
        chk("R9 halted", {15'd0, halted}, 16'h0001);
        chk("R9 no done", 16'(dn), 16'd0);
        chk("R9 no write", 16'(wr), 16'd0);
        chk("R9 pc frozen", pc_out, 16'h1801);
        chk("R9 no reg write", regs_out[15:0] | regs_out[127:16] == '0 ? 16'h0 : 16'h1, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = 16'h0000;
        end
        @(negedge clk);
        ld_en = 1'b0;
        t_reset();
        t_add();
        t_selfmod();
        t_branch();
        t_halt(16'hD000);
        t_halt(16'h1001);
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule